// File: doc/BRIEF.md
# Serial FIFO Extension Interrupt Controller

This block sits beside a byte-wide serial UART that is backed by a large external receive FIFO and a large external transmit FIFO. It holds the configuration that the FIFO path needs: a mode register, an interrupt-enable register, an interval value and a run bit for an external interval timer. It also gives the host a read-only view of the FIFO level flags and of two latched events. All of these sit on a small byte-addressed host bus with single-cycle read and write strobes. A write to the status offset stores nothing. Instead it sends a one-cycle flush strobe to the external FIFOs.

Five interrupt sources share one interrupt line. Each source has its own clear rule, so the host must service each one in the way that suits it. Some sources clear when the host moves data through a FIFO, some clear when it reads the status byte, one follows a level flag directly, and the timer source clears only when the timer is stopped. A mode bit chooses how the line signals: level style holds it high while any enabled source is active, and edge style gives one-cycle pulses. Two gating outputs, taken from the UART's modem-control bits, stop bytes from moving between the UART and each FIFO.

Top module: `fifo_ext_irq_ctrl`

## Requirements
- R1: After reset, every register (mode, enable, interval, timer run) reads 0, no interrupt source is pending, and irq is 0.
- R2: The mode register is at offset 0. Bit 4 selects level interrupts (1) or edge interrupts (0). Bit 3 drives flow_auto_en, bit 2 drives fifo_en and bit 0 drives swap_halves. Bit 1 and bits 7..5 always read 0, whatever is written to them.
- R3: The interrupt-enable register is at offset 1. Bit 0 enables receive half-full, bit 1 transmit half-full, bit 2 transmit empty, bit 3 character timeout and bit 4 timer. Bits 7..5 read 0.
- R4: A read at offset 2 returns, from bit 7 down to bit 0: timer pending, character-timeout pending, NOT rx_full, rx_half, rx_empty, tx_full, tx_half and tx_empty.
- R5: A write to offset 2 raises fifo_flush in that same cycle and changes no register.
- R6: The character-timeout source is set by a char_tmo pulse. It is cleared by rx_fifo_rd or by a status read. When a set and a clear fall in the same cycle, the set wins.
- R7: The transmit-empty source is set when tx_empty rises. It is cleared by tx_fifo_wr or by a status read.
- R8: The transmit-half source is set when tx_half falls. It is cleared while tx_half is 1 (writes have filled the FIFO back to half or more) or by a status read.
- R9: The receive-half source follows rx_half directly, so it clears once reads bring the receive FIFO below half. A status read does not clear it.
- R10: Offset 3 is an 8-bit interval register that drives timer_interval. Bit 0 of offset 4 drives timer_run. The timer source is set by tmr_exp. Only a write of 0 to timer_run clears it; a status read does not.
- R11: In level mode, irq is 1 exactly while at least one enabled source is active.
- R12: In edge mode, irq pulses for one cycle whenever an enabled source becomes active. This includes a source that was already active when its enable bit is set.
- R13: rx_xfer_en is the inverse of modem-control bit 3 and tx_xfer_en is the inverse of modem-control bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Register offset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid in the cycle of the access |
| rx_fifo_rd | input | 1 | Host pops a byte from the receive FIFO |
| tx_fifo_wr | input | 1 | Host pushes a byte into the transmit FIFO |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_half | input | 1 | Receive FIFO at half or more |
| rx_full | input | 1 | Receive FIFO full (active high at this port) |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_half | input | 1 | Transmit FIFO at half or more |
| tx_full | input | 1 | Transmit FIFO full |
| char_tmo | input | 1 | Character-timeout event pulse |
| tmr_exp | input | 1 | Interval-timer expiry pulse |
| mcr_b3 | input | 1 | UART modem-control bit 3 |
| mcr_b2 | input | 1 | UART modem-control bit 2 |
| irq | output | 1 | Interrupt line |
| fifo_flush | output | 1 | Flush strobe to both external FIFOs |
| timer_interval | output | 8 | Interval value for the external timer |
| timer_run | output | 1 | Run enable for the external timer |
| flow_auto_en | output | 1 | Automatic RTS/CTS flow control enable |
| fifo_en | output | 1 | External FIFO enable |
| swap_halves | output | 1 | Swap the two 8-byte halves of the 16-byte window |
| rx_xfer_en | output | 1 | UART-to-receive-FIFO transfer allowed |
| tx_xfer_en | output | 1 | Transmit-FIFO-to-UART transfer allowed |

## Verification
The assertions check the clear rules on every cycle. A status read or receive pop with no new timeout leaves character timeout idle, a push with no new empty edge leaves transmit empty idle, and transmit half stays idle while tx_half is high. They also check that a flush write leaves the mode and enable registers unchanged and that level mode never raises irq with no enabled source active. The bench's scenarios are needed for the rest:
- the bit layout of every register and of the status byte;
- set-wins ordering when a set and a clear fall in the same cycle;
- the single-cycle width of edge pulses, including pulses caused by a write to the enable register;
- the rule that a status read leaves the timer and receive-half sources alone.

// File: rtl/fxi_pkg.sv
package fxi_pkg;
  localparam int ADDR_W = 3;
  localparam int DW     = 8;
  localparam int NSRC   = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_MODE = 3'd0,
    OFF_IEN  = 3'd1,
    OFF_STAT = 3'd2,
    OFF_TIVL = 3'd3,
    OFF_TCTL = 3'd4
  } reg_off_e;

  // source index inside the enable / active vectors
  localparam int SRC_RXH = 0;
  localparam int SRC_TXH = 1;
  localparam int SRC_TXE = 2;
  localparam int SRC_CTO = 3;
  localparam int SRC_TMR = 4;

  // writable bits of the mode register; bit 1 is held at 0
  localparam logic [DW-1:0] MODE_WMASK = 8'h1D;
  localparam int MODE_LVL  = 4;
  localparam int MODE_FLOW = 3;
  localparam int MODE_FIFO = 2;
  localparam int MODE_SWAP = 0;

  function automatic logic [DW-1:0] pack_status(
      input logic tmr, input logic cto, input logic rxf, input logic rxh,
      input logic rxe, input logic txf, input logic txh, input logic txe);
    return {tmr, cto, ~rxf, rxh, rxe, txf, txh, txe};
  endfunction

  function automatic logic rise_any(input logic [NSRC-1:0] now,
                                    input logic [NSRC-1:0] prev);
    return |(now & ~prev);
  endfunction
endpackage

// File: rtl/fxi_regs.sv
module fxi_regs
  import fxi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     status_byte,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     mode_q,
  output logic [NSRC-1:0]   ien_q,
  output logic [DW-1:0]     tivl_q,
  output logic              trun_q,
  output logic              stat_rd,
  output logic              flush_wr,
  output logic              tstop_wr
);
  logic mode_we, ien_we, tivl_we, tctl_we;

  assign mode_we  = wr && (addr == OFF_MODE);
  assign ien_we   = wr && (addr == OFF_IEN);
  assign tivl_we  = wr && (addr == OFF_TIVL);
  assign tctl_we  = wr && (addr == OFF_TCTL);
  assign flush_wr = wr && (addr == OFF_STAT);
  assign stat_rd  = rd && (addr == OFF_STAT);
  assign tstop_wr = tctl_we && !wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
      tivl_q <= '0;
      trun_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= wdata & MODE_WMASK;
      if (ien_we)  ien_q  <= wdata[NSRC-1:0];
      if (tivl_we) tivl_q <= wdata;
      if (tctl_we) trun_q <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      unique case (addr)
        OFF_MODE: rdata = mode_q;
        OFF_IEN:  rdata = {{(DW-NSRC){1'b0}}, ien_q};
        OFF_STAT: rdata = status_byte;
        OFF_TIVL: rdata = tivl_q;
        OFF_TCTL: rdata = {{(DW-1){1'b0}}, trun_q};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fxi_pending.sv
module fxi_pending
  import fxi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            tstop_wr,
  input  logic            rx_fifo_rd,
  input  logic            tx_fifo_wr,
  input  logic            rx_half,
  input  logic            tx_empty,
  input  logic            tx_half,
  input  logic            char_tmo,
  input  logic            tmr_exp,
  output logic [NSRC-1:0] src_act,
  output logic            cto_set,
  output logic            txe_set,
  output logic            txh_set
);
  logic tx_empty_q, tx_half_q;
  logic cto_p, txe_p, txh_p, tmr_p;
  logic cto_clr, txe_clr, txh_clr;

  assign cto_set = char_tmo;
  assign cto_clr = rx_fifo_rd | stat_rd;
  assign txe_set = tx_empty & ~tx_empty_q;
  assign txe_clr = tx_fifo_wr | stat_rd;
  assign txh_set = ~tx_half & tx_half_q;
  assign txh_clr = tx_half | stat_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_empty_q <= 1'b1;
      tx_half_q  <= 1'b0;
      cto_p <= 1'b0;
      txe_p <= 1'b0;
      txh_p <= 1'b0;
      tmr_p <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty;
      tx_half_q  <= tx_half;
      cto_p <= cto_set | (cto_p & ~cto_clr);
      txe_p <= txe_set | (txe_p & ~txe_clr);
      txh_p <= txh_set | (txh_p & ~txh_clr);
      tmr_p <= tmr_exp | (tmr_p & ~tstop_wr);
    end
  end

  always_comb begin
    src_act          = '0;
    src_act[SRC_RXH] = rx_half;
    src_act[SRC_TXH] = txh_p;
    src_act[SRC_TXE] = txe_p;
    src_act[SRC_CTO] = cto_p;
    src_act[SRC_TMR] = tmr_p;
  end
endmodule

// File: rtl/fxi_irq_out.sv
module fxi_irq_out
  import fxi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic [NSRC-1:0] src_act,
  input  logic [NSRC-1:0] ien,
  output logic [NSRC-1:0] armed,
  output logic            irq
);
  logic [NSRC-1:0] armed_q;

  assign armed = src_act & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= '0;
    else        armed_q <= armed;
  end

  assign irq = level_mode ? (|armed) : rise_any(armed, armed_q);
endmodule

// File: rtl/fifo_ext_irq_ctrl.sv
module fifo_ext_irq_ctrl
  import fxi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        rx_fifo_rd,
  input  logic        tx_fifo_wr,
  input  logic        rx_empty,
  input  logic        rx_half,
  input  logic        rx_full,
  input  logic        tx_empty,
  input  logic        tx_half,
  input  logic        tx_full,
  input  logic        char_tmo,
  input  logic        tmr_exp,
  input  logic        mcr_b3,
  input  logic        mcr_b2,
  output logic        irq,
  output logic        fifo_flush,
  output logic [7:0]  timer_interval,
  output logic        timer_run,
  output logic        flow_auto_en,
  output logic        fifo_en,
  output logic        swap_halves,
  output logic        rx_xfer_en,
  output logic        tx_xfer_en
);
  logic [DW-1:0]   mode_q, status_byte;
  logic [NSRC-1:0] ien_q, src_act, armed;
  logic            stat_rd, tstop_wr;
  logic            cto_set, txe_set, txh_set;

  assign status_byte = pack_status(src_act[SRC_TMR], src_act[SRC_CTO], rx_full,
                                   rx_half, rx_empty, tx_full, tx_half, tx_empty);

  fxi_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .wr(host_wr), .rd(host_rd),
    .wdata(host_wdata), .status_byte(status_byte), .rdata(host_rdata),
    .mode_q(mode_q), .ien_q(ien_q), .tivl_q(timer_interval), .trun_q(timer_run),
    .stat_rd(stat_rd), .flush_wr(fifo_flush), .tstop_wr(tstop_wr)
  );

  fxi_pending u_pend (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .tstop_wr(tstop_wr),
    .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr), .rx_half(rx_half),
    .tx_empty(tx_empty), .tx_half(tx_half), .char_tmo(char_tmo),
    .tmr_exp(tmr_exp), .src_act(src_act), .cto_set(cto_set),
    .txe_set(txe_set), .txh_set(txh_set)
  );

  fxi_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .level_mode(mode_q[MODE_LVL]),
    .src_act(src_act), .ien(ien_q), .armed(armed), .irq(irq)
  );

  assign flow_auto_en = mode_q[MODE_FLOW];
  assign fifo_en      = mode_q[MODE_FIFO];
  assign swap_halves  = mode_q[MODE_SWAP];
  assign rx_xfer_en   = ~mcr_b3;
  assign tx_xfer_en   = ~mcr_b2;
endmodule

// File: rtl/fxi_chk.sv
module fxi_chk
  import fxi_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            stat_rd,
  input logic            rx_fifo_rd,
  input logic            tx_fifo_wr,
  input logic            tx_half,
  input logic            cto_set,
  input logic            txe_set,
  input logic            fifo_flush,
  input logic [DW-1:0]   mode_q,
  input logic [NSRC-1:0] ien_q,
  input logic [NSRC-1:0] src_act,
  input logic [NSRC-1:0] armed,
  input logic            irq
);
  a_r6_cto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd || rx_fifo_rd) && !cto_set) |=> !src_act[SRC_CTO]);

  a_r7_txe_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_rd || tx_fifo_wr) && !txe_set) |=> !src_act[SRC_TXE]);

  a_r8_txh_held: assert property (@(posedge clk) disable iff (!rst_n)
    tx_half |=> !src_act[SRC_TXH]);

  a_r5_flush_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> ($stable(mode_q) && $stable(ien_q)));

  a_r11_level_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[MODE_LVL] && ((src_act & ien_q) == '0)) |-> !irq);

  a_r12_edge_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[MODE_LVL] && irq) |-> (armed != '0));
endmodule

bind fifo_ext_irq_ctrl fxi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .rx_fifo_rd(rx_fifo_rd),
  .tx_fifo_wr(tx_fifo_wr), .tx_half(tx_half), .cto_set(cto_set),
  .txe_set(txe_set), .fifo_flush(fifo_flush), .mode_q(mode_q), .ien_q(ien_q),
  .src_act(src_act), .armed(armed), .irq(irq)
);

// File: tb/tb_fifo_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_fifo_ext_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [2:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic rx_fifo_rd = 0, tx_fifo_wr = 0;
  logic rx_empty = 1, rx_half = 0, rx_full = 0;
  logic tx_empty = 1, tx_half = 0, tx_full = 0;
  logic char_tmo = 0, tmr_exp = 0, mcr_b3 = 0, mcr_b2 = 0;
  logic irq, fifo_flush, timer_run, flow_auto_en, fifo_en, swap_halves;
  logic rx_xfer_en, tx_xfer_en;
  logic [7:0] timer_interval;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  fifo_ext_irq_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    step();
    host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; host_rd = 1; #1;
    d = host_rdata;
    step();
    host_rd = 0;
  endtask

  function automatic logic [7:0] stat_exp(input logic tmr, input logic cto);
    return {tmr, cto, !rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1; step();
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      if (a == 2) continue;
      rd(a[2:0], rv); chk("R1 reg", rv, 8'h00);
    end
    chk("R1 irq", irq, 0);
    rd(3'd2, rv); chk("R1 status", rv, stat_exp(0, 0));
    // R2 mode sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, v[7:0]); rd(3'd0, rv);
      chk("R2 mode", rv, v & 8'h1D);
      chk("R2 pins", {flow_auto_en, fifo_en, swap_halves}, {v[3], v[2], v[0]});
    end
    // R3 enable sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd1, v[7:0]); rd(3'd1, rv); chk("R3 ien", rv, v & 8'h1F);
    end
    // R10 interval and run sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd3, v[7:0]); rd(3'd3, rv); chk("R10 interval", rv, v[7:0]);
      chk("R10 interval pin", timer_interval, v[7:0]);
      wr(3'd4, v[7:0]); rd(3'd4, rv); chk("R10 run", rv, v & 1);
      chk("R10 run pin", timer_run, v[0]);
    end
    wr(3'd4, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'h10);
    // R4 status layout over every flag combination
    for (int i = 0; i < 64; i++) begin
      {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty} = i[5:0];
      step(); rd(3'd2, rv); chk("R4 status", rv, stat_exp(0, 0));
    end
    {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty} = 6'b001001;
    step(); step(); rd(3'd2, rv);
    // R5 flush
    wr(3'd0, 8'h1D); wr(3'd1, 8'h00);
    host_addr = 3'd2; host_wdata = 8'hFF; host_wr = 1; #1;
    chk("R5 flush strobe", fifo_flush, 1);
    step(); host_wr = 0; #1;
    chk("R5 flush ends", fifo_flush, 0);
    rd(3'd0, rv); chk("R5 mode kept", rv, 8'h1D);
    rd(3'd1, rv); chk("R5 ien kept", rv, 8'h00);
    wr(3'd0, 8'h10);
    // R6 character timeout
    char_tmo = 1; step(); char_tmo = 0;
    rd(3'd2, rv); chk("R6 cto set", rv, stat_exp(0, 1));
    rd(3'd2, rv); chk("R6 cleared by status read", rv, stat_exp(0, 0));
    char_tmo = 1; step(); char_tmo = 0;
    rx_fifo_rd = 1; step(); rx_fifo_rd = 0;
    rd(3'd2, rv); chk("R6 cleared by rx pop", rv, stat_exp(0, 0));
    char_tmo = 1; rx_fifo_rd = 1; step(); char_tmo = 0; rx_fifo_rd = 0;
    rd(3'd2, rv); chk("R6 set wins", rv, stat_exp(0, 1));
    // R7 transmit empty, level mode, only bit 2 enabled
    wr(3'd1, 8'h04);
    tx_empty = 0; step(); chk("R7 idle", irq, 0);
    tx_empty = 1; step(); chk("R7 set on rise", irq, 1);
    tx_fifo_wr = 1; step(); tx_fifo_wr = 0; chk("R7 cleared by push", irq, 0);
    tx_empty = 0; step(); tx_empty = 1; step(); chk("R7 set again", irq, 1);
    rd(3'd2, rv); chk("R7 cleared by status read", irq, 0);
    // R8 transmit half, only bit 1 enabled
    wr(3'd1, 8'h02);
    tx_half = 1; step(); chk("R8 idle", irq, 0);
    tx_half = 0; step(); chk("R8 set on fall", irq, 1);
    tx_half = 1; step(); chk("R8 cleared by refill", irq, 0);
    tx_half = 0; step(); chk("R8 set again", irq, 1);
    rd(3'd2, rv); chk("R8 cleared by status read", irq, 0);
    // R9 receive half, only bit 0 enabled
    wr(3'd1, 8'h01);
    rx_half = 1; #1; chk("R9 follows flag", irq, 1);
    rd(3'd2, rv); chk("R9 not cleared by status read", irq, 1);
    rx_half = 0; #1; chk("R9 clears below half", irq, 0);
    // R11 disabled source stays silent
    wr(3'd1, 8'h00); rx_half = 1; #1; chk("R11 disabled", irq, 0);
    rx_half = 0;
    // R10 timer source, R11 level
    wr(3'd1, 8'h10); wr(3'd4, 8'h01);
    tmr_exp = 1; step(); tmr_exp = 0;
    chk("R11 level timer", irq, 1);
    rd(3'd2, rv); chk("R10 status bit7", rv, stat_exp(1, 0));
    chk("R10 survives status read", irq, 1);
    wr(3'd4, 8'h00); chk("R10 cleared by stop", irq, 0);
    // R12 edge mode
    wr(3'd0, 8'h00); wr(3'd1, 8'h01);
    rx_half = 1; #1; chk("R12 pulse", irq, 1);
    step(); chk("R12 single cycle", irq, 0);
    rx_half = 0; step();
    wr(3'd1, 8'h00); rx_half = 1; step();
    wr(3'd1, 8'h01); chk("R12 pulse on enable", irq, 1);
    step(); chk("R12 enable pulse ends", irq, 0);
    wr(3'd0, 8'h10); chk("R11 level after switch", irq, 1);
    rx_half = 0;
    // R13 transfer gating
    for (int m = 0; m < 4; m++) begin
      {mcr_b3, mcr_b2} = m[1:0]; #1;
      chk("R13 gating", {rx_xfer_en, tx_xfer_en}, {!m[1], !m[0]});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule